// File: doc/BRIEF.md
# Memory Access Permission Checker

This block sits beside the memory address path and judges each CPU or DMA access in the cycle it is presented. It uses the access address, size and direction, the requester's privilege, and the page bits that the page map returns for the page. It reports at once whether the access may go ahead. On a violation it records a general status word and two bus status words that describe the fault. One cycle later it issues a bus error pulse to the CPU, or a level-7 interrupt pulse for DMA, provided the error enable input is high. Address translation and the page map itself belong to neighbouring logic.

A long access whose far end lands in a different 4 KB page is judged a second time, using the page bits of that second page. The map supplies them on a second page-bit input. Status words keep their value until the next fault or an explicit clear. A faulting read returns all-ones data, trimmed to the access width, in place of memory data.

Top module: `bus_fault_guard`

## Requirements
- R1: Page bits are {write_enable, state[1:0]}, and state 00 means the page is absent. An access to an address below 0x400000 whose page state is 00 faults as "absent", whatever the requester, and this check takes priority over every other rule.
- R2: When R1 does not apply, any access with `cpu_super` or `dma_req` high is allowed.
- R3: A user access at or above 0x400000 faults as "illegal area".
- R4: A user access below 0x080000 (address bits 22:19 all zero) faults as "protected". The exception is a read at an address of 0x1000 or less, which is allowed.
- R5: A user write to a page whose write_enable bit (bit 2) is 0 faults as "protected". User reads of such a page are allowed.
- R6: For a CPU fault the general status is 0x8BFF/0x9AFF/0x9BFF on a write and 0xCBFF/0xDAFF/0xDBFF on a read, for absent, illegal area and protected respectively.
- R7: For a DMA fault the general status is 0xABFF/0xBAFF/0xBBFF, with 0x4000 added on a read. When `gen_flag_en` is high, 0x0400 is added to the general status of any fault.
- R8: Size encoding is 00 byte, 01 word, 10 long. For a CPU fault, bus status 0 is 0x7C00 for word or long, 0x7E00 for a byte at an odd address and 0x7D00 for a byte at an even address. For a DMA fault it is 0x3C00. Fault address bits 23:16 are ORed into its low byte. Bus status 1 holds fault address bits 15:0.
- R9: A long write whose address+3 falls in another 4 KB page is judged again at address+3 using `page_bits_b`, and the recorded fault address stays the original one. A long read whose address+2 crosses a page is judged again at address+2, and that address is recorded.
- R10: One cycle after a fault, `bus_err` pulses for a CPU fault or `lvl7_req` pulses for a DMA fault. Neither pulses when `err_en` is low, but the status words are captured either way.
- R11: Reset and `stat_clr` set all three status words to 0xFFFF. The words hold between faults and clears. A fault in the same cycle as a clear wins.
- R12: During a faulting read, `cpu_rdata` is 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or long. Otherwise it passes `mem_rdata` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | An access is presented this cycle |
| acc_addr | input | 24 | Logical access address |
| acc_size | input | 2 | 00 byte, 01 word, 10 long |
| acc_wr | input | 1 | 1 write, 0 read |
| cpu_super | input | 1 | CPU is in supervisor mode |
| dma_req | input | 1 | Access comes from the DMA engine |
| page_bits_a | input | 3 | {write_enable, state[1:0]} of the page holding acc_addr |
| page_bits_b | input | 3 | Page bits of the following page, used for a page-crossing long access |
| err_en | input | 1 | Enables bus error and level-7 pulses |
| gen_flag_en | input | 1 | Adds 0x0400 into the general status on faults |
| stat_clr | input | 1 | Sets all status words to 0xFFFF |
| mem_rdata | input | 32 | Read data from memory |
| acc_ok | output | 1 | Access allowed (combinational) |
| acc_fault | output | 1 | Access violates a rule (combinational) |
| bus_err | output | 1 | One-cycle bus error pulse for the CPU |
| lvl7_req | output | 1 | One-cycle level-7 interrupt pulse for DMA faults |
| gen_status | output | 16 | General status word |
| bus_stat0 | output | 16 | Bus status word 0 |
| bus_stat1 | output | 16 | Bus status word 1 (fault address low half) |
| cpu_rdata | output | 32 | Read data returned to the requester |

## Verification
On every cycle the assertions check several rules. An absent low page always faults, a privileged access to present pages never faults, and a user access to the upper area always faults. The error enable gates the pulses, a clear resets the status words, and the words hold when nothing happens. The fill data of faulting reads is checked the same way. The exact status encodings depend on the fault class, requester, direction, size and byte lane. These, together with the kernel-read exception and the page-crossing rechecks and the address each one records, are shown only by the bench's vector table and directed scenarios.

// File: rtl/bfg_pkg.sv
package bfg_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } acc_size_e;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_ABSENT = 2'd1,
        FC_AREA   = 2'd2,
        FC_PROT   = 2'd3
    } fault_cls_e;

    typedef struct packed {
        logic [15:0] gen;
        logic [15:0] bsr0;
        logic [15:0] bsr1;
        logic        berr;
        logic        irq7;
    } stat_s;

endpackage

// File: rtl/bfg_classifier.sv
// Applies the ordered permission rules to one address.
module bfg_classifier
    import bfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE    = 24'h400000,
    parameter logic [ADDR_W-1:0] KERN_SPAN  = 24'h080000,
    parameter logic [ADDR_W-1:0] LOW_RD_MAX = 24'h001000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              priv,
    input  logic [2:0]        pbits,
    output fault_cls_e        cls
);
    logic in_ram;
    logic in_kern;
    logic low_read;

    always_comb begin
        in_ram   = (addr < IO_BASE);
        in_kern  = (addr < KERN_SPAN);
        low_read = !wr && (addr <= LOW_RD_MAX);
        if (in_ram && (pbits[1:0] == 2'b00)) begin
            cls = FC_ABSENT;
        end else if (priv) begin
            cls = FC_NONE;
        end else if (!in_ram) begin
            cls = FC_AREA;
        end else if (in_kern && !low_read) begin
            cls = FC_PROT;
        end else if (wr && !pbits[2]) begin
            cls = FC_PROT;
        end else begin
            cls = FC_NONE;
        end
    end
endmodule

// File: rtl/bfg_encoder.sv
// Builds the general and bus status words for a classified fault.
module bfg_encoder
    import bfg_pkg::*;
(
    input  fault_cls_e        cls,
    input  logic              wr,
    input  logic              dma,
    input  logic              flag_en,
    input  acc_size_e         size,
    input  logic [ADDR_W-1:0] faddr,
    output logic [15:0]       gen,
    output logic [15:0]       bsr0,
    output logic [15:0]       bsr1
);
    logic [7:0] kind;

    always_comb begin
        // high byte: 1, read, dma, not-absent, 1, flag, 1, not-area
        gen = {1'b1, !wr, dma, (cls != FC_ABSENT), 1'b1, flag_en, 1'b1,
               (cls != FC_AREA), 8'hFF};
        if (dma) begin
            kind = 8'h3C;
        end else if (size == SZ_BYTE) begin
            kind = faddr[0] ? 8'h7E : 8'h7D;
        end else begin
            kind = 8'h7C;
        end
        bsr0 = {kind, faddr[ADDR_W-1:16]};
        bsr1 = faddr[15:0];
    end
endmodule

// File: rtl/bus_fault_guard.sv
module bus_fault_guard
    import bfg_pkg::*;
#(
    parameter int                PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] IO_BASE    = 24'h400000,
    parameter logic [ADDR_W-1:0] KERN_SPAN  = 24'h080000,
    parameter logic [ADDR_W-1:0] LOW_RD_MAX = 24'h001000,
    parameter int                N_CHECKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_wr,
    input  logic              cpu_super,
    input  logic              dma_req,
    input  logic [2:0]        page_bits_a,
    input  logic [2:0]        page_bits_b,
    input  logic              err_en,
    input  logic              gen_flag_en,
    input  logic              stat_clr,
    input  logic [31:0]       mem_rdata,
    output logic              acc_ok,
    output logic              acc_fault,
    output logic              bus_err,
    output logic              lvl7_req,
    output logic [15:0]       gen_status,
    output logic [15:0]       bus_stat0,
    output logic [15:0]       bus_stat1,
    output logic [31:0]       cpu_rdata
);
    localparam int PAGE_HI = ADDR_W - 1;
    localparam logic [15:0] CLEAR_WORD = 16'hFFFF;

    acc_size_e         size;
    logic [ADDR_W-1:0] far_addr;
    logic              crosses;
    logic [ADDR_W-1:0] chk_addr [N_CHECKS];
    logic [2:0]        chk_bits [N_CHECKS];
    fault_cls_e        chk_cls  [N_CHECKS];
    fault_cls_e        cls;
    logic [ADDR_W-1:0] fault_addr;
    logic [15:0]       enc_gen, enc_bsr0, enc_bsr1;
    stat_s             st_d, st_q;

    // second probe: +3 for writes, +2 for reads
    always_comb begin
        size     = acc_size_e'(acc_size);
        far_addr = acc_addr + (acc_wr ? ADDR_W'(3) : ADDR_W'(2));
        crosses  = (size == SZ_LONG) &&
                   (far_addr[PAGE_HI:PAGE_SHIFT] != acc_addr[PAGE_HI:PAGE_SHIFT]);
        chk_addr[0] = acc_addr;
        chk_bits[0] = page_bits_a;
        chk_addr[1] = far_addr;
        chk_bits[1] = page_bits_b;
    end

    for (genvar g = 0; g < N_CHECKS; g++) begin : g_chk
        bfg_classifier #(
            .IO_BASE    (IO_BASE),
            .KERN_SPAN  (KERN_SPAN),
            .LOW_RD_MAX (LOW_RD_MAX)
        ) u_cls (
            .addr  (chk_addr[g]),
            .wr    (acc_wr),
            .priv  (cpu_super || dma_req),
            .pbits (chk_bits[g]),
            .cls   (chk_cls[g])
        );
    end

    always_comb begin
        if (chk_cls[0] != FC_NONE) begin
            cls        = chk_cls[0];
            fault_addr = acc_addr;
        end else if (crosses) begin
            cls        = chk_cls[1];
            fault_addr = acc_wr ? acc_addr : far_addr;
        end else begin
            cls        = FC_NONE;
            fault_addr = acc_addr;
        end
    end

    bfg_encoder u_enc (
        .cls     (cls),
        .wr      (acc_wr),
        .dma     (dma_req),
        .flag_en (gen_flag_en),
        .size    (size),
        .faddr   (fault_addr),
        .gen     (enc_gen),
        .bsr0    (enc_bsr0),
        .bsr1    (enc_bsr1)
    );

    always_comb begin
        acc_fault = acc_req && (cls != FC_NONE);
        acc_ok    = acc_req && (cls == FC_NONE);
        unique case (size)
            SZ_BYTE: cpu_rdata = acc_fault && !acc_wr ? 32'h0000_00FF : mem_rdata;
            SZ_WORD: cpu_rdata = acc_fault && !acc_wr ? 32'h0000_FFFF : mem_rdata;
            default: cpu_rdata = acc_fault && !acc_wr ? 32'hFFFF_FFFF : mem_rdata;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.berr = 1'b0;
        st_d.irq7 = 1'b0;
        if (stat_clr) begin
            st_d.gen  = CLEAR_WORD;
            st_d.bsr0 = CLEAR_WORD;
            st_d.bsr1 = CLEAR_WORD;
        end
        if (acc_fault) begin
            st_d.gen  = enc_gen;
            st_d.bsr0 = enc_bsr0;
            st_d.bsr1 = enc_bsr1;
            st_d.berr = err_en && !dma_req;
            st_d.irq7 = err_en && dma_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{gen: CLEAR_WORD, bsr0: CLEAR_WORD, bsr1: CLEAR_WORD,
                      berr: 1'b0, irq7: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_status = st_q.gen;
    assign bus_stat0  = st_q.bsr0;
    assign bus_stat1  = st_q.bsr1;
    assign bus_err    = st_q.berr;
    assign lvl7_req   = st_q.irq7;
endmodule

// File: rtl/bfg_checker.sv
module bfg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_req,
    input logic [23:0] acc_addr,
    input logic [1:0]  acc_size,
    input logic        acc_wr,
    input logic        cpu_super,
    input logic        dma_req,
    input logic [2:0]  page_bits_a,
    input logic [2:0]  page_bits_b,
    input logic        err_en,
    input logic        stat_clr,
    input logic        acc_fault,
    input logic        bus_err,
    input logic        lvl7_req,
    input logic [15:0] gen_status,
    input logic [15:0] bus_stat0,
    input logic [15:0] bus_stat1,
    input logic [31:0] cpu_rdata
);
    p_absent_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && (acc_addr < 24'h400000) && (page_bits_a[1:0] == 2'b00) |-> acc_fault);

    p_priv_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && (cpu_super || dma_req) && (page_bits_a[1:0] != 2'b00)
        && (page_bits_b[1:0] != 2'b00) |-> !acc_fault);

    p_user_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !cpu_super && !dma_req && (acc_addr >= 24'h400000) |-> acc_fault);

    p_berr_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault && err_en && !dma_req |=> bus_err && !lvl7_req);

    p_irq_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault && err_en && dma_req |=> lvl7_req && !bus_err);

    p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_en || !acc_fault |=> !bus_err && !lvl7_req);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && !acc_fault |=> gen_status == 16'hFFFF && bus_stat0 == 16'hFFFF
        && bus_stat1 == 16'hFFFF);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr && !acc_fault |=> $stable(gen_status) && $stable(bus_stat0)
        && $stable(bus_stat1));

    p_fill_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault && !acc_wr && acc_size == 2'b00 |-> cpu_rdata == 32'h0000_00FF);

    p_fill_long_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault && !acc_wr && acc_size == 2'b10 |-> cpu_rdata == 32'hFFFF_FFFF);
endmodule

bind bus_fault_guard bfg_checker u_bfg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_req     (acc_req),
    .acc_addr    (acc_addr),
    .acc_size    (acc_size),
    .acc_wr      (acc_wr),
    .cpu_super   (cpu_super),
    .dma_req     (dma_req),
    .page_bits_a (page_bits_a),
    .page_bits_b (page_bits_b),
    .err_en      (err_en),
    .stat_clr    (stat_clr),
    .acc_fault   (acc_fault),
    .bus_err     (bus_err),
    .lvl7_req    (lvl7_req),
    .gen_status  (gen_status),
    .bus_stat0   (bus_stat0),
    .bus_stat1   (bus_stat1),
    .cpu_rdata   (cpu_rdata)
);

// File: tb/bus_fault_guard_test.sv
module bus_fault_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_wr = 1'b0;
    logic        cpu_super = 1'b0;
    logic        dma_req = 1'b0;
    logic [2:0]  page_bits_a = '0;
    logic [2:0]  page_bits_b = '0;
    logic        err_en = 1'b0;
    logic        gen_flag_en = 1'b0;
    logic        stat_clr = 1'b0;
    logic [31:0] mem_rdata = 32'h1234_5678;
    logic        acc_ok, acc_fault, bus_err, lvl7_req;
    logic [15:0] gen_status, bus_stat0, bus_stat1;
    logic [31:0] cpu_rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_fault_guard uut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wr(acc_wr), .cpu_super(cpu_super),
        .dma_req(dma_req), .page_bits_a(page_bits_a), .page_bits_b(page_bits_b),
        .err_en(err_en), .gen_flag_en(gen_flag_en), .stat_clr(stat_clr),
        .mem_rdata(mem_rdata), .acc_ok(acc_ok), .acc_fault(acc_fault),
        .bus_err(bus_err), .lvl7_req(lvl7_req), .gen_status(gen_status),
        .bus_stat0(bus_stat0), .bus_stat1(bus_stat1), .cpu_rdata(cpu_rdata)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [23:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic        sup;
        logic        dma;
        logic [2:0]  pba;
        logic [2:0]  pbb;
        logic        flag;
        logic        fault;
        logic [15:0] gen;
        logic [15:0] b0;
        logic [15:0] b1;
    } vec_t;

    localparam int NV = 20;
    // req, addr, size, wr, sup, dma, pba, pbb, flag, fault, gen, bsr0, bsr1
    localparam vec_t VECS [NV] = '{
        {4'd2,  24'h123456, 2'd0, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R2 user ok
        {4'd1,  24'h0A2000, 2'd1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b101, 1'b0, 1'b1, 16'h8BFF, 16'h7C0A, 16'h2000}, // R1 R6
        {4'd7,  24'h3A0011, 2'd0, 1'b0, 1'b1, 1'b0, 3'b100, 3'b101, 1'b1, 1'b1, 16'hCFFF, 16'h7E3A, 16'h0011}, // R1 R7 R8
        {4'd3,  24'h450000, 2'd1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 16'hDAFF, 16'h7C45, 16'h0000}, // R3 R6
        {4'd8,  24'hE40010, 2'd0, 1'b1, 1'b0, 1'b0, 3'b101, 3'b101, 1'b0, 1'b1, 16'h9AFF, 16'h7DE4, 16'h0010}, // R3 R8
        {4'd4,  24'h001000, 2'd1, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R4 boundary read
        {4'd4,  24'h001002, 2'd1, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101, 1'b0, 1'b1, 16'hDBFF, 16'h7C00, 16'h1002}, // R4
        {4'd4,  24'h000800, 2'd1, 1'b1, 1'b0, 1'b0, 3'b101, 3'b101, 1'b0, 1'b1, 16'h9BFF, 16'h7C00, 16'h0800}, // R4 write
        {4'd1,  24'h000800, 2'd1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b101, 1'b0, 1'b1, 16'h8BFF, 16'h7C00, 16'h0800}, // R1 priority
        {4'd5,  24'h100000, 2'd1, 1'b1, 1'b0, 1'b0, 3'b001, 3'b001, 1'b0, 1'b1, 16'h9BFF, 16'h7C10, 16'h0000}, // R5
        {4'd5,  24'h100000, 2'd1, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R5 read ok
        {4'd7,  24'h080000, 2'd1, 1'b1, 1'b0, 1'b1, 3'b000, 3'b101, 1'b0, 1'b1, 16'hABFF, 16'h3C08, 16'h0000}, // R7 dma wr
        {4'd7,  24'h200004, 2'd1, 1'b0, 1'b0, 1'b1, 3'b000, 3'b101, 1'b1, 1'b1, 16'hEFFF, 16'h3C20, 16'h0004}, // R7 dma rd
        {4'd2,  24'h000100, 2'd1, 1'b1, 1'b0, 1'b1, 3'b001, 3'b001, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R2 dma
        {4'd2,  24'h000100, 2'd1, 1'b1, 1'b1, 1'b0, 3'b001, 3'b001, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R2 super
        {4'd9,  24'h100FFE, 2'd2, 1'b1, 1'b0, 1'b0, 3'b101, 3'b001, 1'b0, 1'b1, 16'h9BFF, 16'h7C10, 16'h0FFE}, // R9 wr
        {4'd9,  24'h100FFE, 2'd2, 1'b0, 1'b0, 1'b0, 3'b101, 3'b000, 1'b0, 1'b1, 16'hCBFF, 16'h7C10, 16'h1000}, // R9 rd
        {4'd9,  24'h100FFC, 2'd2, 1'b1, 1'b0, 1'b0, 3'b101, 3'b000, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R9 no cross
        {4'd9,  24'h100FFE, 2'd2, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R9 both ok
        {4'd2,  24'h500000, 2'd1, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}  // R2 dma high
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [23:0] a, input logic [1:0] sz, input logic w,
                         input logic s, input logic d, input logic [2:0] pa,
                         input logic [2:0] pb);
        acc_req = 1'b1; acc_addr = a; acc_size = sz; acc_wr = w;
        cpu_super = s; dma_req = d; page_bits_a = pa; page_bits_b = pb;
    endtask

    task automatic clear_stat();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        check(gen_status == 16'hFFFF, "R11 reset gen", 32'(gen_status), 32'hFFFF);
        check(bus_stat0 == 16'hFFFF, "R11 reset bsr0", 32'(bus_stat0), 32'hFFFF);
        check(bus_stat1 == 16'hFFFF, "R11 reset bsr1", 32'(bus_stat1), 32'hFFFF);
        check(!bus_err && !lvl7_req && !acc_ok, "R10 reset pulses", 32'(bus_err), 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            string tag = $sformatf("R%0d vec%0d", v.req, i);
            @(negedge clk);
            drive(v.addr, v.size, v.wr, v.sup, v.dma, v.pba, v.pbb);
            gen_flag_en = v.flag;
            #1;
            check(acc_fault == v.fault, tag, 32'(acc_fault), 32'(v.fault));
            check(acc_ok == !v.fault, tag, 32'(acc_ok), 32'(!v.fault));
            @(negedge clk);
            acc_req = 1'b0;
            check(gen_status == v.gen, tag, 32'(gen_status), 32'(v.gen));
            check(bus_stat0 == v.b0, tag, 32'(bus_stat0), 32'(v.b0));
            check(bus_stat1 == v.b1, tag, 32'(bus_stat1), 32'(v.b1));
            // R10: err_en low, no pulses though status captured
            check(!bus_err && !lvl7_req, {tag, " R10 masked"}, 32'({bus_err, lvl7_req}), 0);
            gen_flag_en = 1'b0;
            clear_stat();
        end

        // R10 CPU fault with errors enabled
        err_en = 1'b1;
        @(negedge clk); drive(24'h450000, 2'd1, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101);
        @(negedge clk); acc_req = 1'b0;
        check(bus_err && !lvl7_req, "R10 cpu berr", 32'({bus_err, lvl7_req}), 32'b10);
        @(negedge clk);
        check(!bus_err, "R10 berr one cycle", 32'(bus_err), 0);
        // R10 DMA fault
        @(negedge clk); drive(24'h010000, 2'd1, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000);
        @(negedge clk); acc_req = 1'b0;
        check(lvl7_req && !bus_err, "R10 dma lvl7", 32'({bus_err, lvl7_req}), 32'b01);
        check(gen_status == 16'hABFF, "R10 dma status", 32'(gen_status), 32'hABFF);
        err_en = 1'b0;

        // R11 hold across an allowed access, then clear
        @(negedge clk); drive(24'h123456, 2'd1, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101);
        @(negedge clk); acc_req = 1'b0;
        check(gen_status == 16'hABFF, "R11 hold", 32'(gen_status), 32'hABFF);
        clear_stat();
        check(bus_stat0 == 16'hFFFF, "R11 clear", 32'(bus_stat0), 32'hFFFF);
        // R11 fault beats clear in the same cycle
        @(negedge clk); drive(24'h0A2000, 2'd1, 1'b1, 1'b0, 1'b0, 3'b000, 3'b101);
        stat_clr = 1'b1;
        @(negedge clk); acc_req = 1'b0; stat_clr = 1'b0;
        check(gen_status == 16'h8BFF, "R11 fault wins", 32'(gen_status), 32'h8BFF);
        check(bus_stat1 == 16'h2000, "R11 fault wins bsr1", 32'(bus_stat1), 32'h2000);

        // R12 read fill data
        @(negedge clk); drive(24'h450001, 2'd0, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101); #1;
        check(cpu_rdata == 32'h0000_00FF, "R12 byte", cpu_rdata, 32'h0000_00FF);
        @(negedge clk); drive(24'h450000, 2'd1, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101); #1;
        check(cpu_rdata == 32'h0000_FFFF, "R12 word", cpu_rdata, 32'h0000_FFFF);
        @(negedge clk); drive(24'h450000, 2'd2, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101); #1;
        check(cpu_rdata == 32'hFFFF_FFFF, "R12 long", cpu_rdata, 32'hFFFF_FFFF);
        @(negedge clk); drive(24'h123456, 2'd1, 1'b0, 1'b0, 1'b0, 3'b101, 3'b101); #1;
        check(cpu_rdata == 32'h1234_5678, "R12 pass", cpu_rdata, 32'h1234_5678);
        @(negedge clk); acc_req = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule